// File: doc/BRIEF.md
# Ethernet Transmit FIFO with Collision Replay and Underrun Retry

This block is the transmit-side frame buffer between a host DMA engine and an Ethernet MAC. The DMA side pushes bytes, each tagged with an end-of-frame flag. The MAC side pulls bytes one at a time. The buffer decides when the MAC may begin draining the oldest frame. The normal start rule is a programmable byte threshold. A frame whose final byte has already arrived may always start.

Every byte of the frame currently being sent stays in storage until that frame leaves. Two events use this. When the MAC reports a collision early in a frame, the read pointer returns to the frame's first byte, and the frame is replayed without a second host fetch. When the MAC reports an underrun, the frame is replayed in store-and-forward mode, which means it starts only once it is complete in storage. The block allows a bounded number of underrun retries. It reports one status pulse per frame as the frame leaves.

Backoff timing, framing, CRC and descriptor handling belong to the MAC and the DMA engine. This block only reacts to their collision and underrun pulses.

Top module: `eth_tx_retry_fifo`

## Requirements
- R1: `wr_ready` is 1 only when fewer than DEPTH (2048) bytes are held and fewer than MAX_FR (2) complete frames are held. Each byte of the frame being sent counts as held until that frame's last byte has left.
- R2: The oldest frame begins to be offered (`rd_valid`=1) in two ways:
  - if no complete frame is held and the held byte count is nonzero and at least `start_thresh`;
  - as soon as that frame's end-of-frame byte has been written, whatever the threshold.
- R3: Bytes leave in write order. `rd_last` is 1 exactly on each frame's final byte. Consecutive frames follow one another with no re-ordering.
- R4: A `mac_collision` pulse while fewer than COL_WIN (64) bytes of the frame have been accepted by the MAC rewinds the frame to its first byte. The whole frame is then offered again.
- R5: A `mac_collision` pulse once COL_WIN or more bytes have been accepted (a late collision) discards the rest of the frame without offering it. The frame leaves with `fr_late_col`=1, and the bytes it occupied are released.
- R6: A `mac_underrun` pulse during a frame rewinds it to its first byte and holds it back until its last byte has been written, ignoring the threshold. The frame is then offered from the start. `fr_retries` counts these retries.
- R7: After MAX_UR (3) underrun retries, a further underrun discards the remainder of the frame. The frame then reports `fr_underrun_fail`=1 and `fr_retries`=3. Its discarded bytes never appear on the read port.
- R8: The forced full-frame wait applies only to the retried frame. The next frame starts on the programmed threshold again.
- R9: `fr_done` pulses for exactly one cycle, in the cycle after a frame's last byte is accepted or discarded.
  - `fr_underrun_fail`, `fr_late_col` and `fr_retries` are meaningful only alongside `fr_done` and are 0 otherwise.
  - At most one of `fr_underrun_fail` and `fr_late_col` is set.
- R10: After reset the buffer is empty: `wr_ready`=1, `rd_valid`=0 and `fr_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host byte present |
| wr_data | input | 8 | Host byte |
| wr_last | input | 1 | Host byte ends its frame |
| wr_ready | output | 1 | Buffer can take a byte this cycle |
| rd_valid | output | 1 | Byte offered to the MAC |
| rd_data | output | 8 | Offered byte |
| rd_last | output | 1 | Offered byte ends its frame |
| rd_ready | input | 1 | MAC takes the offered byte |
| start_thresh | input | 12 | Byte count that lets a partial frame start |
| mac_collision | input | 1 | Collision pulse from the MAC |
| mac_underrun | input | 1 | Underrun pulse from the MAC |
| fr_done | output | 1 | Frame left the buffer (one cycle) |
| fr_underrun_fail | output | 1 | Frame dropped after exhausting underrun retries |
| fr_late_col | output | 1 | Frame dropped by a late collision |
| fr_retries | output | 2 | Underrun retries used by the frame |

## Verification
A frame-start pointer that slips shows up as wrong bytes on the read port. This appears after the next collision or underrun rewind, because the replay would not begin with the frame's first byte. A wrong complete-frame count shows up within a cycle or two as a frame that starts too early, or one that never starts. It can also hold `wr_ready` low with space available. Errors in the retry counter or the drop state surface in the single `fr_done` cycle as wrong flags. They can also surface as stray bytes from a discarded frame ahead of the next frame.

// File: rtl/txr_pkg.sv
package txr_pkg;

  typedef enum logic [1:0] {
    RS_WAIT = 2'd0,
    RS_SEND = 2'd1,
    RS_DROP = 2'd2
  } rd_state_e;

  // Bytes between two ring pointers that carry one wrap bit.
  function automatic int unsigned ring_used(int unsigned w, int unsigned f, int unsigned pw);
    return (w - f) & ((32'd1 << pw) - 32'd1);
  endfunction

  // Start rule for the oldest frame.
  function automatic logic may_start(int unsigned whole, logic sf, int unsigned used,
                                     int unsigned thr);
    return (whole != 0) || (!sf && used != 0 && used >= thr);
  endfunction

  // Collision still inside the replay window?
  function automatic logic in_window(int unsigned sent, int unsigned win);
    return sent < win;
  endfunction

  function automatic int unsigned sat_inc(int unsigned v, int unsigned top);
    return (v >= top) ? top : v + 32'd1;
  endfunction

endpackage

// File: rtl/txr_store.sv
module txr_store
  import txr_pkg::*;
#(
  parameter int DEPTH  = 2048,
  parameter int MAX_FR = 2,
  parameter int PW     = $clog2(DEPTH) + 1,
  parameter int FW     = $clog2(MAX_FR + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [7:0]    wr_data,
  input  logic          wr_last,
  output logic          wr_ready,
  input  logic [PW-1:0] rd_ptr,
  input  logic [PW-1:0] free_ptr,
  input  logic          leave,
  output logic [PW-1:0] wptr,
  output logic [FW-1:0] whole_cnt,
  output logic [7:0]    byte_data,
  output logic          byte_last
);
  localparam int AW = PW - 1;

  logic [8:0]    mem [DEPTH];
  logic [PW-1:0] used;
  logic          wr_fire;
  logic          eof_in;

  assign used      = PW'(ring_used(32'(wptr), 32'(free_ptr), PW));
  assign wr_ready  = (32'(used) < DEPTH) && (32'(whole_cnt) < MAX_FR);
  assign wr_fire   = wr_valid && wr_ready;
  assign eof_in    = wr_fire && wr_last;
  assign byte_data = mem[rd_ptr[AW-1:0]][7:0];
  assign byte_last = mem[rd_ptr[AW-1:0]][8];

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wptr[AW-1:0]] <= {wr_last, wr_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr      <= '0;
      whole_cnt <= '0;
    end else begin
      if (wr_fire) wptr <= wptr + 1'b1;
      whole_cnt <= whole_cnt + FW'(eof_in) - FW'(leave);
    end
  end

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    32'(used) <= DEPTH);
  assert_frame_limit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    32'(whole_cnt) <= MAX_FR);
  assert_leave_whole_R9: assert property (@(posedge clk) disable iff (!rst_n)
    leave |-> (whole_cnt != '0));

endmodule

// File: rtl/txr_rdctl.sv
module txr_rdctl
  import txr_pkg::*;
#(
  parameter int DEPTH   = 2048,
  parameter int MAX_FR  = 2,
  parameter int COL_WIN = 64,
  parameter int MAX_UR  = 3,
  parameter int PW      = $clog2(DEPTH) + 1,
  parameter int FW      = $clog2(MAX_FR + 1),
  parameter int SW      = $clog2(COL_WIN + 1),
  parameter int UW      = $clog2(MAX_UR + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] wptr,
  input  logic [FW-1:0] whole_cnt,
  input  logic [PW-1:0] thresh,
  input  logic          byte_last,
  input  logic          rd_ready,
  input  logic          col,
  input  logic          undr,
  output logic [PW-1:0] rptr,
  output logic [PW-1:0] fstart,
  output logic          rd_valid,
  output logic          rd_last,
  output logic          leave,
  output logic          fr_done,
  output logic          fr_ufail,
  output logic          fr_late,
  output logic [UW-1:0] fr_retries
);
  rd_state_e     state;
  logic [SW-1:0] sent;
  logic [UW-1:0] ur;
  logic          sf, late_q, ufail_q;
  logic          have, xfer, drop_step;
  logic          early_col, late_col, ur_retry, ur_fail, start_go;

  assign have      = rptr != wptr;
  assign rd_valid  = (state == RS_SEND) && have;
  assign rd_last   = rd_valid && byte_last;
  assign xfer      = rd_valid && rd_ready && !col && !undr;
  assign drop_step = (state == RS_DROP) && have;
  assign leave     = (xfer || drop_step) && byte_last;
  assign early_col = (state == RS_SEND) && col && in_window(32'(sent), COL_WIN);
  assign late_col  = (state == RS_SEND) && col && !in_window(32'(sent), COL_WIN);
  assign ur_retry  = (state == RS_SEND) && !col && undr && (32'(ur) < MAX_UR);
  assign ur_fail   = (state == RS_SEND) && !col && undr && !(32'(ur) < MAX_UR);
  assign start_go  = (state == RS_WAIT) &&
                     may_start(32'(whole_cnt), sf,
                               ring_used(32'(wptr), 32'(fstart), PW), 32'(thresh));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= RS_WAIT;
      rptr       <= '0;
      fstart     <= '0;
      sent       <= '0;
      ur         <= '0;
      sf         <= 1'b0;
      late_q     <= 1'b0;
      ufail_q    <= 1'b0;
      fr_done    <= 1'b0;
      fr_ufail   <= 1'b0;
      fr_late    <= 1'b0;
      fr_retries <= '0;
    end else begin
      fr_done    <= 1'b0;
      fr_ufail   <= 1'b0;
      fr_late    <= 1'b0;
      fr_retries <= '0;
      if (leave) begin
        state      <= RS_WAIT;
        rptr       <= rptr + 1'b1;
        fstart     <= rptr + 1'b1;
        fr_done    <= 1'b1;
        fr_ufail   <= ufail_q;
        fr_late    <= late_q;
        fr_retries <= ur;
        sent       <= '0;
        ur         <= '0;
        sf         <= 1'b0;
        late_q     <= 1'b0;
        ufail_q    <= 1'b0;
      end else begin
        unique case (state)
          RS_WAIT: if (start_go) state <= RS_SEND;
          RS_SEND: begin
            if (early_col) begin
              rptr <= fstart;
              sent <= '0;
            end else if (late_col) begin
              state  <= RS_DROP;
              late_q <= 1'b1;
            end else if (ur_retry) begin
              ur    <= ur + 1'b1;
              rptr  <= fstart;
              sent  <= '0;
              sf    <= 1'b1;
              state <= RS_WAIT;
            end else if (ur_fail) begin
              state   <= RS_DROP;
              ufail_q <= 1'b1;
            end else if (xfer) begin
              rptr <= rptr + 1'b1;
              sent <= SW'(sat_inc(32'(sent), COL_WIN));
            end
          end
          RS_DROP: if (drop_step) begin
            rptr   <= rptr + 1'b1;
            fstart <= rptr + 1'b1;
          end
          default: state <= RS_WAIT;
        endcase
      end
    end
  end

  assert_early_rewind_R4: assert property (@(posedge clk) disable iff (!rst_n)
    early_col |=> (rptr == fstart && state == RS_SEND));
  assert_late_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    late_col |=> (state == RS_DROP));
  assert_sf_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RS_WAIT && sf && whole_cnt == '0) |=> (state == RS_WAIT));
  assert_retry_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ur) <= MAX_UR);
  assert_flag_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fr_ufail, fr_late}));
  assert_flag_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_ufail || fr_late || fr_retries != '0) |-> fr_done);
  assert_clean_finish_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && rd_last && !col && !undr) |=> (fr_done && !fr_ufail && !fr_late));

endmodule

// File: rtl/eth_tx_retry_fifo.sv
module eth_tx_retry_fifo
  import txr_pkg::*;
#(
  parameter int DEPTH   = 2048,
  parameter int MAX_FR  = 2,
  parameter int COL_WIN = 64,
  parameter int MAX_UR  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_valid,
  input  logic [7:0]                 wr_data,
  input  logic                       wr_last,
  output logic                       wr_ready,
  output logic                       rd_valid,
  output logic [7:0]                 rd_data,
  output logic                       rd_last,
  input  logic                       rd_ready,
  input  logic [$clog2(DEPTH):0]     start_thresh,
  input  logic                       mac_collision,
  input  logic                       mac_underrun,
  output logic                       fr_done,
  output logic                       fr_underrun_fail,
  output logic                       fr_late_col,
  output logic [$clog2(MAX_UR+1)-1:0] fr_retries
);
  localparam int PW = $clog2(DEPTH) + 1;
  localparam int FW = $clog2(MAX_FR + 1);
  localparam int SW = $clog2(COL_WIN + 1);
  localparam int UW = $clog2(MAX_UR + 1);

  logic [PW-1:0] wptr, rptr, fstart;
  logic [FW-1:0] whole_cnt;
  logic          byte_last, leave;

  txr_store #(.DEPTH(DEPTH), .MAX_FR(MAX_FR), .PW(PW), .FW(FW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last), .wr_ready(wr_ready),
    .rd_ptr(rptr), .free_ptr(fstart), .leave(leave),
    .wptr(wptr), .whole_cnt(whole_cnt), .byte_data(rd_data), .byte_last(byte_last)
  );

  txr_rdctl #(.DEPTH(DEPTH), .MAX_FR(MAX_FR), .COL_WIN(COL_WIN), .MAX_UR(MAX_UR),
              .PW(PW), .FW(FW), .SW(SW), .UW(UW)) u_rdctl (
    .clk(clk), .rst_n(rst_n),
    .wptr(wptr), .whole_cnt(whole_cnt), .thresh(start_thresh), .byte_last(byte_last),
    .rd_ready(rd_ready), .col(mac_collision), .undr(mac_underrun),
    .rptr(rptr), .fstart(fstart), .rd_valid(rd_valid), .rd_last(rd_last), .leave(leave),
    .fr_done(fr_done), .fr_ufail(fr_underrun_fail), .fr_late(fr_late_col),
    .fr_retries(fr_retries)
  );

endmodule

// File: tb/eth_tx_retry_fifo_bench.sv
`timescale 1ns/1ps
module eth_tx_retry_fifo_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0, wr_last = 1'b0, rd_ready = 1'b0;
  logic [7:0]  wr_data = 8'd0;
  logic [11:0] start_thresh = 12'd16;
  logic        mac_collision = 1'b0, mac_underrun = 1'b0;
  logic        wr_ready, rd_valid, rd_last, fr_done, fr_underrun_fail, fr_late_col;
  logic [7:0]  rd_data;
  logic [1:0]  fr_retries;

  int tests = 0;
  int fails = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  eth_tx_retry_fifo u_eth_tx_retry_fifo (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last),
    .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
    .rd_ready(rd_ready), .start_thresh(start_thresh), .mac_collision(mac_collision),
    .mac_underrun(mac_underrun), .fr_done(fr_done), .fr_underrun_fail(fr_underrun_fail),
    .fr_late_col(fr_late_col), .fr_retries(fr_retries)
  );

  function automatic logic [7:0] pat(int id, int i);
    return 8'(id * 37 + i * 11 + 3);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put_byte(logic [7:0] d, logic l);
    wr_valid = 1'b1; wr_data = d; wr_last = l;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0; wr_last = 1'b0;
  endtask

  task automatic put_range(int id, int from, int to, bit last_at_to, bit idle);
    for (int i = from; i <= to; i++) begin
      if (idle) repeat ($urandom_range(0, 2)) @(negedge clk);
      put_byte(pat(id, i), last_at_to && (i == to));
    end
  endtask

  task automatic get_byte(output logic [7:0] d, output logic l, input bit stall);
    if (stall) repeat ($urandom_range(0, 2)) @(negedge clk);
    rd_ready = 1'b1;
    while (!rd_valid) @(negedge clk);
    d = rd_data; l = rd_last;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic read_check(int id, int from, int to, bit last_at_to, string tag, bit stall);
    int errs = 0;
    int first_bad = -1;
    int got_bad = 0;
    for (int i = from; i <= to; i++) begin
      logic [7:0] d;
      logic l;
      get_byte(d, l, stall);
      if (d !== pat(id, i) || l !== (last_at_to && i == to)) begin
        if (first_bad < 0) begin first_bad = i; got_bad = int'(d); end
        errs++;
      end
    end
    check(errs == 0, $sformatf("%s frame %0d byte %0d data", tag, id, first_bad),
          got_bad, (first_bad < 0) ? 0 : int'(pat(id, first_bad)));
  endtask

  task automatic check_status(bit uf, bit lc, int rt, string tag);
    check(fr_done === 1'b1, {tag, " fr_done"}, int'(fr_done), 1);
    check(fr_underrun_fail === uf && fr_late_col === lc && int'(fr_retries) == rt,
          {tag, " flags {ufail,late,retries}"},
          int'({fr_underrun_fail, fr_late_col, fr_retries}), int'({uf, lc, 2'(rt)}));
  endtask

  task automatic wait_done(bit uf, bit lc, int rt, string tag);
    int n = 0;
    while (!fr_done && n < 6000) begin @(negedge clk); n++; end
    check_status(uf, lc, rt, tag);
  endtask

  task automatic pulse_col();
    mac_collision = 1'b1; @(negedge clk); mac_collision = 1'b0;
  endtask

  task automatic pulse_undr();
    mac_underrun = 1'b1; @(negedge clk); mac_underrun = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      fails++;
      $display("FAIL watchdog: run did not finish, got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int lens[12];
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(wr_ready === 1'b1, "R10 wr_ready after reset", int'(wr_ready), 1);
    check(rd_valid === 1'b0, "R10 rd_valid after reset", int'(rd_valid), 0);
    check(fr_done === 1'b0, "R10 fr_done after reset", int'(fr_done), 0);

    // R2 threshold start, R3 order, R9 single pulse
    start_thresh = 12'd10;
    put_range(1, 0, 8, 0, 0);
    repeat (5) @(negedge clk);
    check(rd_valid === 1'b0, "R2 below threshold", int'(rd_valid), 0);
    put_range(1, 9, 9, 0, 0);
    repeat (2) @(negedge clk);
    check(rd_valid === 1'b1, "R2 threshold reached", int'(rd_valid), 1);
    put_range(1, 10, 19, 1, 0);
    read_check(1, 0, 19, 1, "R3", 0);
    check_status(0, 0, 0, "R9 clean frame");
    @(negedge clk);
    check(fr_done === 1'b0, "R9 pulse one cycle", int'(fr_done), 0);

    // R2 end-of-frame overrides threshold
    start_thresh = 12'd100;
    put_range(2, 0, 4, 1, 0);
    repeat (2) @(negedge clk);
    check(rd_valid === 1'b1, "R2 eof start", int'(rd_valid), 1);
    read_check(2, 0, 4, 1, "R2", 0);
    check_status(0, 0, 0, "R2 eof frame");

    // R1 complete-frame limit, R3 back to back
    start_thresh = 12'd2048;
    put_range(3, 0, 5, 1, 0);
    put_range(4, 0, 6, 1, 0);
    @(negedge clk);
    check(wr_ready === 1'b0, "R1 two frames held", int'(wr_ready), 0);
    read_check(3, 0, 5, 1, "R3", 0);
    check_status(0, 0, 0, "R3 frame A");
    @(negedge clk);
    check(wr_ready === 1'b1, "R1 space after leave", int'(wr_ready), 1);
    read_check(4, 0, 6, 1, "R3", 0);
    check_status(0, 0, 0, "R3 frame B");

    // R4 early collision at 63 bytes sent
    start_thresh = 12'd4;
    put_range(5, 0, 79, 1, 0);
    read_check(5, 0, 62, 0, "R4 first pass", 0);
    pulse_col();
    read_check(5, 0, 79, 1, "R4 replay", 0);
    check_status(0, 0, 0, "R4 replayed frame");

    // R6 underrun retry in store-and-forward, R8 next frame threshold
    start_thresh = 12'd8;
    put_range(6, 0, 19, 0, 0);
    read_check(6, 0, 19, 0, "R6 first pass", 0);
    pulse_undr();
    repeat (4) @(negedge clk);
    check(rd_valid === 1'b0, "R6 waits for whole frame", int'(rd_valid), 0);
    put_range(6, 20, 39, 1, 0);
    repeat (2) @(negedge clk);
    check(rd_valid === 1'b1, "R6 restarts when complete", int'(rd_valid), 1);
    read_check(6, 0, 39, 1, "R6 replay", 0);
    check_status(0, 0, 1, "R6 retried frame");
    put_range(7, 0, 9, 0, 0);
    repeat (2) @(negedge clk);
    check(rd_valid === 1'b1, "R8 threshold restored", int'(rd_valid), 1);
    put_range(7, 10, 14, 1, 0);
    read_check(7, 0, 14, 1, "R8", 0);
    check_status(0, 0, 0, "R8 next frame");

    // R7 retries exhausted
    put_range(8, 0, 29, 1, 0);
    for (int k = 0; k < 4; k++) begin
      read_check(8, 0, 4, 0, "R7 attempt", 0);
      pulse_undr();
    end
    wait_done(1, 0, 3, "R7 failed frame");
    @(negedge clk);
    check(rd_valid === 1'b0, "R7 dropped bytes gone", int'(rd_valid), 0);
    put_range(9, 0, 11, 1, 0);
    read_check(9, 0, 11, 1, "R7 following frame", 0);
    check_status(0, 0, 0, "R7 following frame");

    // R1 byte capacity, R5 late collision at 64 bytes
    start_thresh = 12'd2048;
    put_range(10, 0, 2047, 0, 0);
    @(negedge clk);
    check(wr_ready === 1'b0, "R1 full at DEPTH", int'(wr_ready), 0);
    check(rd_valid === 1'b1, "R2 full threshold", int'(rd_valid), 1);
    read_check(10, 0, 63, 0, "R5 before collision", 0);
    pulse_col();
    put_range(10, 2048, 2048, 1, 0);
    wait_done(0, 1, 0, "R5 late collision");
    put_range(11, 0, 2, 1, 0);
    read_check(11, 0, 2, 1, "R5 recovery", 0);
    check_status(0, 0, 0, "R5 recovery frame");

    // R3 constrained random traffic
    start_thresh = 12'($urandom_range(1, 300));
    foreach (lens[i]) lens[i] = $urandom_range(1, 300);
    fork
      begin
        foreach (lens[i]) put_range(100 + i, 0, lens[i] - 1, 1, 1);
      end
      begin
        foreach (lens[i]) begin
          read_check(100 + i, 0, lens[i] - 1, 1, "R3 random", 1);
          check_status(0, 0, 0, "R3 random status");
        end
      end
    join

    ended = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule